// File: doc/BRIEF.md
# Shadow Register Bank with Atomic Commit

This block holds a bank of channels. Each channel has a staging register and an active register. Upstream logic loads the staging side one channel at a time, in any order, using a store strobe for each channel. A channel can also be left untouched between publications. A single commit strobe then moves every staged value into the active side on one clock edge. Whatever reads the active side therefore never sees a mix of old and new values.

A process strobe samples the active set into a bank of output registers. The downstream function is given a frozen, committed snapshot to work on.

Status outputs report the following:
- which channels hold staged data not yet published;
- whether any channel is in that state;
- a one-cycle pulse that follows each commit.

All strobes are synchronous enables on one clock, and none of them acts as a clock.

Top module: `shadow_commit_bank`

## Requirements
- R1: Synchronous reset clears every staging register, active register, output register and pending flag to zero, and drives the commit-done pulse low.
- R2: A channel's staging register takes its data slice only on a clock edge where that channel's store strobe is high. Channel i uses bits [i*W +: W] of the flat data, active and output buses.
- R3: A channel whose store strobe stays low keeps its previously staged value across any number of cycles and commits.
- R4: On a commit edge every channel's active register takes its staged value, all on that same edge.
- R5: Active registers change only on edges where commit is high. Staging writes alone leave them unchanged.
- R6: If a channel's store strobe and the commit strobe are high on the same edge, that channel's active register and its staging register both take the new data.
- R7: A channel's pending flag goes to 1 on an edge where it is stored. Otherwise it goes to 0 on a commit edge, and otherwise it holds. The any-pending output is the OR of all pending flags.
- R8: The commit-done output is high for exactly the one cycle that follows a commit edge.
- R9: On an edge with the process strobe high, the output registers take the active values as they were before that edge. If commit falls on the same edge, the outputs take the previous committed set. Without the process strobe the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data_i | input | N*W | Staging data, one W-bit slice per channel |
| wr_en_i | input | N | Store strobe, one bit per channel |
| commit_i | input | 1 | Publish all staged values |
| process_i | input | 1 | Capture the active set into the outputs |
| act_o | output | N*W | Active (committed) values |
| out_o | output | N*W | Captured snapshot for the consumer |
| pend_o | output | N | Pending flag for each channel |
| pend_any_o | output | 1 | OR of all pending flags |
| commit_done_o | output | 1 | One-cycle pulse after a commit |

## Verification
Two events can land on one edge: a store on a channel and a commit, and separately a commit and a process capture. The stimulus table places a store on some channels in the same cycle as a commit. The result is judged on three things: the active value must be the fresh data, the other channels must take their staged values, and the written channels must stay pending. A later row raises process and commit together, and the outputs must show the set committed before that edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DEF_CHANNELS = 4;
  localparam int DEF_WIDTH    = 16;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STAGE = 2'd1,
    SRC_DATA  = 2'd2
  } act_src_e;

  // Source of the next active value for one channel.
  function automatic act_src_e forward_sel(input logic store, input logic commit);
    if (!commit)    return SRC_HOLD;
    else if (store) return SRC_DATA;
    else            return SRC_STAGE;
  endfunction
endpackage

// File: rtl/sc_channel.sv
module sc_channel
  import sc_pkg::*;
#(
  parameter int W = DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         store,
  input  logic         commit,
  input  logic [W-1:0] din,
  output logic [W-1:0] act_o,
  output logic         pend_o
);
  logic [W-1:0] stg_q;
  logic [W-1:0] act_q;
  logic         pend_q;
  act_src_e     src;

  assign src = forward_sel(store, commit);

  always_ff @(posedge clk) begin
    if (rst)        stg_q <= '0;
    else if (store) stg_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else begin
      case (src)
        SRC_DATA:  act_q <= din;
        SRC_STAGE: act_q <= stg_q;
        default:   act_q <= act_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (store)  pend_q <= 1'b1;
    else if (commit) pend_q <= 1'b0;
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;

  AST_STG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !store |=> $stable(stg_q)); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_q)); // R5
  AST_COMMIT_STAGE: assert property (@(posedge clk) disable iff (rst)
    (commit && !store) |=> (act_q == $past(stg_q))); // R4
  AST_COMMIT_FWD: assert property (@(posedge clk) disable iff (rst)
    (commit && store) |=> (act_q == $past(din) && stg_q == $past(din))); // R6
  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    store |=> pend_q); // R7
endmodule

// File: rtl/sc_commit_ctl.sv
module sc_commit_ctl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [N-1:0] pend,
  output logic         done_o,
  output logic         any_o
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= commit;
  end

  assign done_o = done_q;
  assign any_o  = |pend;

  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (rst)
    commit |=> done_q); // R8
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !commit |=> !done_q); // R8
endmodule

// File: rtl/sc_publish.sv
module sc_publish #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          process,
  input  logic [DW-1:0] act,
  output logic [DW-1:0] out_o
);
  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst)          out_q <= '0;
    else if (process) out_q <= act;
  end

  assign out_o = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !process |=> $stable(out_q)); // R9
  AST_OUT_SNAP: assert property (@(posedge clk) disable iff (rst)
    process |=> (out_q == $past(act))); // R9
endmodule

// File: rtl/shadow_commit_bank.sv
module shadow_commit_bank
  import sc_pkg::*;
#(
  parameter int N = DEF_CHANNELS,
  parameter int W = DEF_WIDTH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*W-1:0] wr_data_i,
  input  logic [N-1:0]   wr_en_i,
  input  logic           commit_i,
  input  logic           process_i,
  output logic [N*W-1:0] act_o,
  output logic [N*W-1:0] out_o,
  output logic [N-1:0]   pend_o,
  output logic           pend_any_o,
  output logic           commit_done_o
);
  localparam int DW = N * W;

  logic [DW-1:0] act_bus;
  logic [N-1:0]  pend_bus;
  logic          commit_fire;
  logic          process_fire;

  assign commit_fire  = commit_i;
  assign process_fire = process_i;

  for (genvar g = 0; g < N; g++) begin : g_ch
    sc_channel #(.W(W)) i_ch (
      .clk    (clk),
      .rst    (rst),
      .store  (wr_en_i[g]),
      .commit (commit_fire),
      .din    (wr_data_i[g*W +: W]),
      .act_o  (act_bus[g*W +: W]),
      .pend_o (pend_bus[g])
    );
  end

  sc_commit_ctl #(.N(N)) i_ctl (
    .clk    (clk),
    .rst    (rst),
    .commit (commit_fire),
    .pend   (pend_bus),
    .done_o (commit_done_o),
    .any_o  (pend_any_o)
  );

  sc_publish #(.DW(DW)) i_pub (
    .clk     (clk),
    .rst     (rst),
    .process (process_fire),
    .act     (act_bus),
    .out_o   (out_o)
  );

  assign act_o  = act_bus;
  assign pend_o = pend_bus;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (act_o == '0 && out_o == '0 && pend_o == '0 && !commit_done_o)); // R1
endmodule

// File: tb/test_shadow_commit_bank.sv
module test_shadow_commit_bank;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int DW = N * W;
  localparam int ROWS = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] wr_data_i;
  logic [N-1:0]  wr_en_i;
  logic          commit_i;
  logic          process_i;
  logic [DW-1:0] act_o;
  logic [DW-1:0] out_o;
  logic [N-1:0]  pend_o;
  logic          pend_any_o;
  logic          commit_done_o;

  always #4 clk = ~clk;

  shadow_commit_bank #(.N(N), .W(W)) i_shadow_commit_bank (
    .clk           (clk),
    .rst           (rst),
    .wr_data_i     (wr_data_i),
    .wr_en_i       (wr_en_i),
    .commit_i      (commit_i),
    .process_i     (process_i),
    .act_o         (act_o),
    .out_o         (out_o),
    .pend_o        (pend_o),
    .pend_any_o    (pend_any_o),
    .commit_done_o (commit_done_o)
  );

  // Row: {wr_en[3:0], base[11:0], commit, process, exp_pend[3:0], exp_done}
  typedef struct packed {
    logic [3:0]  wr;
    logic [11:0] base;
    logic        cm;
    logic        pr;
    logic [3:0]  xpend;
    logic        xdone;
  } row_t;

  localparam row_t TABLE [ROWS] = '{
    '{4'b0001, 12'h111, 1'b0, 1'b0, 4'b0001, 1'b0},
    '{4'b0100, 12'h222, 1'b0, 1'b0, 4'b0101, 1'b0},
    '{4'b0000, 12'h000, 1'b1, 1'b0, 4'b0000, 1'b1},
    '{4'b0000, 12'h000, 1'b0, 1'b1, 4'b0000, 1'b0},
    '{4'b1010, 12'h333, 1'b1, 1'b0, 4'b1010, 1'b1},
    '{4'b0000, 12'h000, 1'b1, 1'b0, 4'b0000, 1'b1},
    '{4'b1111, 12'h444, 1'b0, 1'b1, 4'b1111, 1'b0},
    '{4'b0011, 12'h555, 1'b0, 1'b0, 4'b1111, 1'b0},
    '{4'b0000, 12'h000, 1'b1, 1'b1, 4'b0000, 1'b1},
    '{4'b0000, 12'h000, 1'b0, 1'b1, 4'b0000, 1'b0}
  };

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_stg, m_act, m_out;

  function automatic logic [DW-1:0] mkword(input logic [11:0] base);
    logic [DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = {base, 4'(i)};
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en_i = '0; wr_data_i = '0; commit_i = 1'b0; process_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    step(); step();
    // R1: reset state
    check("R1", "act",  act_o, '0);
    check("R1", "out",  out_o, '0);
    check("R1", "pend", DW'(pend_o), '0);
    check("R1", "done", DW'(commit_done_o), '0);
    rst = 1'b0;
    m_stg = '0; m_act = '0; m_out = '0;

    for (int r = 0; r < ROWS; r++) begin
      logic [DW-1:0] d;
      logic [DW-1:0] n_stg, n_act;
      d = mkword(TABLE[r].base);
      wr_en_i = TABLE[r].wr; wr_data_i = d;
      commit_i = TABLE[r].cm; process_i = TABLE[r].pr;
      // Model: R2/R3 staging, R4/R5/R6 active, R9 outputs
      n_stg = m_stg; n_act = m_act;
      for (int i = 0; i < N; i++) begin
        if (TABLE[r].wr[i]) n_stg[i*W +: W] = d[i*W +: W];
        if (TABLE[r].cm) n_act[i*W +: W] = TABLE[r].wr[i] ? d[i*W +: W] : m_stg[i*W +: W];
      end
      if (TABLE[r].pr) m_out = m_act;
      m_stg = n_stg; m_act = n_act;
      step();
      idle();
      check("R4/R5/R6", $sformatf("act row %0d", r), act_o, m_act);
      check("R9", $sformatf("out row %0d", r), out_o, m_out);
      check("R7", $sformatf("pend row %0d", r), DW'(pend_o), DW'(TABLE[r].xpend));
      check("R7", $sformatf("any row %0d", r), DW'(pend_any_o), DW'(|TABLE[r].xpend));
      check("R8", $sformatf("done row %0d", r), DW'(commit_done_o), DW'(TABLE[r].xdone));
    end

    // R8: pulse lasts one cycle only
    step();
    check("R8", "done drops", DW'(commit_done_o), '0);

    // R3: untouched channels keep staged value over idle cycles and commit
    wr_en_i = 4'b0001; wr_data_i = mkword(12'h666);
    step(); idle();
    step(); step();
    commit_i = 1'b1;
    step(); idle();
    check("R3", "keep staged", act_o,
          {mkword(12'h555)[DW-1:W], mkword(12'h666)[W-1:0]} & {{(DW-2*W){1'b0}}, {(2*W){1'b1}}}
          | (m_act & {{(DW-2*W){1'b1}}, {(2*W){1'b0}}}));

    // R1: reset mid-operation clears everything, staging included
    wr_en_i = 4'b1111; wr_data_i = mkword(12'h777); commit_i = 1'b1; process_i = 1'b1;
    step(); idle();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1", "act after reset", act_o, '0);
    check("R1", "out after reset", out_o, '0);
    check("R1", "pend after reset", DW'(pend_o), '0);
    commit_i = 1'b1;
    step(); idle();
    check("R1", "staging cleared", act_o, '0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule